// File: doc/BRIEF.md
# Serial Presence Memory Write-Protection Controller

This block is the acceptance logic of a 256-byte serial presence memory whose lower half (addresses 00h to 7Fh) can be locked by software. A bit-level bus engine reports each received byte. For every byte it gives the bus phase (device select, address or data) and the byte value. The block answers each byte with an acknowledge decision. On a data byte it also says whether the engine may start an internal write cycle. When that write cycle completes, the engine pulses `wr_done`, and only then does a pending protection instruction change the lock state.

Two lock bits are kept. A resettable lock protects the lower half. A permanent lock protects the lower half and also silences every protection instruction. Both bits model non-volatile storage, so `rst_n` does not touch them. They start cleared at power-up, and `rst_n` clears only the context of the instruction in progress. The write-control pin is sampled when the select byte arrives and is held for the rest of that instruction.

All pins are plain control signals. There is no back-pressure: the engine presents at most one byte per `ph_strobe` pulse, and each answer appears exactly one clock later.

Top module: `spd_wp_ctrl`

## Requirements
- R1: A select byte whose upper nibble is 1010b (bits 7:4) addresses the memory array. It is acknowledged, for either value of bit 0 (1 = read), when bits 3:1 equal `ce_pins[2:0]`. Otherwise it gets NoAck, and so does every later byte of that instruction.
- R2: A select byte with upper nibble 0110b is a protection instruction. With `hv_e0` high, bits 3:1 = 001 together with `ce_pins[2:1]` = 00 decode as lock-set, and bits 3:1 = 011 together with `ce_pins[2:1]` = 01 decode as lock-clear. With `hv_e0` low, bits 3:1 equal to `ce_pins` decode as permanent-lock. Any other combination gets NoAck.
- R3: When `wc_pin` is high, every data byte of a write-form instruction gets NoAck and produces no `commit_ok`, at any address.
- R4: When `wc_pin` is low and either lock is active, a memory write gets Ack on its select and address bytes. A data byte aimed at 00h–7Fh gets NoAck and no commit. A data byte aimed at 80h–FFh is acknowledged and committed.
- R5: Once the permanent lock is set, every 0110b select byte gets NoAck in both read and write forms, and the lower half stays protected. The lock never clears, whatever the instructions, the `wc_pin` level or `rst_n`.
- R6: With only the resettable lock active, a lock-set select gets NoAck. Lock-clear and permanent-lock are fully acknowledged and committed when `wc_pin` is low. When `wc_pin` is high, their data byte gets NoAck.
- R7: With no lock and `wc_pin` low, all three protection instructions and memory writes are acknowledged on every byte and committed. With `wc_pin` high, their data byte gets NoAck.
- R8: A read-form instruction (select bit 0 = 1) has its select byte acknowledged under the same rule as its write form. Its address and data bytes always get NoAck.
- R9: A committed protection instruction changes the lock state only on `wr_done`. Committed instructions apply as follows: lock-set sets the resettable lock, lock-clear clears it, and permanent-lock sets the permanent lock. A pending instruction is dropped when the next select byte arrives without a `wr_done`.
- R10: `wc_pin` is captured on the select byte. A change of `wc_pin` later in the same instruction has no effect on its acknowledges.
- R11: `ack_valid` is high exactly one clock after each `ph_strobe`, and only then. `ack` and `commit_ok` are valid in that cycle, and `commit_ok` is low at all other times.
- R12: After `rst_n` both outputs are low, and address or data bytes that arrive without a new select byte get NoAck. The lock state from before the reset still governs later instructions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of instruction context (not of the lock bits) |
| ph_strobe | input | 1 | One-cycle pulse: a byte has been received |
| ph_kind | input | 2 | Phase of that byte: 0 select, 1 address, 2 data |
| bus_byte | input | 8 | Received byte value |
| ce_pins | input | 3 | Chip-enable pin levels {E2,E1,E0} |
| hv_e0 | input | 1 | High voltage detected on the E0 pin |
| wc_pin | input | 1 | Write-control pin level, high = array protected |
| wr_done | input | 1 | Internal write cycle has completed |
| ack_valid | output | 1 | Decision for the last strobed byte is present |
| ack | output | 1 | 1 = acknowledge, 0 = NoAck |
| commit_ok | output | 1 | Data byte accepted; a write cycle may start |

## Verification
Each decision is registered once, so the answer to a strobe appears on the clock edge after it. The driver task pushes the expected acknowledge and commit into a queue as it raises `ph_strobe` on a falling edge. The monitor pops and compares on the next falling edge, half a cycle after the answer settles. A response with nothing expected, or a `commit_ok` outside `ack_valid`, counts as a failure. Lock changes take effect on the edge that samples `wr_done`. The bench therefore releases `wr_done` a full cycle before the next select byte, so every later acknowledge reflects the new state.

// File: rtl/spd_wp_pkg.sv
`timescale 1ns/1ps
package spd_wp_pkg;
  typedef enum logic [1:0] {
    PH_SEL  = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2
  } bus_phase_e;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_MEM  = 3'd1,
    OP_SET  = 3'd2,
    OP_CLR  = 3'd3,
    OP_PERM = 3'd4
  } wp_op_e;

  typedef struct packed {
    wp_op_e op;
    logic   rd;
    logic   wc;
    logic   hit;
    logic   upper;
  } instr_ctx_t;
endpackage

// File: rtl/spd_sel_decode.sv
`timescale 1ns/1ps
module spd_sel_decode
  import spd_wp_pkg::*;
#(
  parameter logic [3:0] MEM_TYPE  = 4'b1010,
  parameter logic [3:0] PROT_TYPE = 4'b0110,
  parameter int         CE_W      = 3
) (
  input  logic [7:0]      sel_byte,
  input  logic [CE_W-1:0] ce_pins,
  input  logic            hv_e0,
  output wp_op_e          op
);
  localparam logic [CE_W-1:0] SET_CS = CE_W'(3'b001);
  localparam logic [CE_W-1:0] CLR_CS = CE_W'(3'b011);

  logic [3:0]      dev_type;
  logic [CE_W-1:0] cs_bits;

  assign dev_type = sel_byte[7:4];
  assign cs_bits  = sel_byte[CE_W:1];

  always_comb begin
    op = OP_NONE;
    if (dev_type == MEM_TYPE) begin
      if (cs_bits == ce_pins) op = OP_MEM;
    end else if (dev_type == PROT_TYPE) begin
      if (hv_e0) begin
        if (cs_bits == SET_CS && ce_pins[CE_W-1:1] == SET_CS[CE_W-1:1])
          op = OP_SET;
        else if (cs_bits == CLR_CS && ce_pins[CE_W-1:1] == CLR_CS[CE_W-1:1])
          op = OP_CLR;
      end else if (cs_bits == ce_pins) begin
        op = OP_PERM;
      end
    end
  end
endmodule

// File: rtl/spd_lock_state.sv
`timescale 1ns/1ps
module spd_lock_state
  import spd_wp_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   sel_evt,
  input  logic   commit_evt,
  input  wp_op_e commit_op,
  input  logic   wr_done,
  output logic   soft_lock,
  output logic   perm_lock
);
  wp_op_e pend_q;
  logic   soft_nv;
  logic   perm_nv;

  // Pending protection instruction, part of the volatile instruction context
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pend_q <= OP_NONE;
    else if (sel_evt)    pend_q <= OP_NONE;
    else if (wr_done)    pend_q <= OP_NONE;
    else if (commit_evt) pend_q <= commit_op;
  end

  // Non-volatile lock bits: cleared at power-up only, untouched by rst_n
  initial begin
    soft_nv = 1'b0;
    perm_nv = 1'b0;
  end

  always @(posedge clk) begin
    if (wr_done) begin
      case (pend_q)
        OP_SET:  soft_nv <= 1'b1;
        OP_CLR:  soft_nv <= 1'b0;
        OP_PERM: perm_nv <= 1'b1;
        default: ;
      endcase
    end
  end

  assign perm_lock = perm_nv;
  assign soft_lock = soft_nv | perm_nv;

  // R5
  perm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    perm_lock |=> perm_lock);

  // R9
  lock_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_lock != $past(soft_lock) || perm_lock != $past(perm_lock)) |-> $past(wr_done));
endmodule

// File: rtl/spd_ack_matrix.sv
`timescale 1ns/1ps
module spd_ack_matrix
  import spd_wp_pkg::*;
(
  input  wp_op_e     sel_op,
  input  instr_ctx_t ctx,
  input  logic       soft_lock,
  input  logic       perm_lock,
  output logic       sel_ack,
  output logic       addr_ack,
  output logic       data_ack
);
  logic write_form;
  logic area_open;

  always_comb begin
    case (sel_op)
      OP_MEM:          sel_ack = 1'b1;
      OP_SET:          sel_ack = !soft_lock && !perm_lock;
      OP_CLR, OP_PERM: sel_ack = !perm_lock;
      default:         sel_ack = 1'b0;
    endcase
  end

  assign write_form = ctx.hit && !ctx.rd && (ctx.op != OP_NONE);
  assign area_open  = (ctx.op != OP_MEM) || ctx.upper || !soft_lock;
  assign addr_ack   = write_form;
  assign data_ack   = write_form && !ctx.wc && area_open;
endmodule

// File: rtl/spd_wp_ctrl.sv
`timescale 1ns/1ps
module spd_wp_ctrl
  import spd_wp_pkg::*;
#(
  parameter int         ADDR_W    = 8,
  parameter int         CE_W      = 3,
  parameter logic [3:0] MEM_TYPE  = 4'b1010,
  parameter logic [3:0] PROT_TYPE = 4'b0110
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ph_strobe,
  input  logic [1:0]      ph_kind,
  input  logic [7:0]      bus_byte,
  input  logic [CE_W-1:0] ce_pins,
  input  logic            hv_e0,
  input  logic            wc_pin,
  input  logic            wr_done,
  output logic            ack_valid,
  output logic            ack,
  output logic            commit_ok
);
  localparam int HALF_BIT = ADDR_W - 1;

  wp_op_e     sel_op;
  instr_ctx_t ctx_q;
  logic       sel_ack, addr_ack, data_ack;
  logic       soft_lock, perm_lock;
  logic       sel_evt, addr_evt, data_evt, commit_evt;
  logic       resp_sel_q;

  assign sel_evt    = ph_strobe && (ph_kind == PH_SEL);
  assign addr_evt   = ph_strobe && (ph_kind == PH_ADDR);
  assign data_evt   = ph_strobe && (ph_kind == PH_DATA);
  assign commit_evt = data_evt && data_ack && (ctx_q.op != OP_MEM);

  spd_sel_decode #(
    .MEM_TYPE (MEM_TYPE),
    .PROT_TYPE(PROT_TYPE),
    .CE_W     (CE_W)
  ) u_decode (
    .sel_byte(bus_byte),
    .ce_pins (ce_pins),
    .hv_e0   (hv_e0),
    .op      (sel_op)
  );

  spd_ack_matrix u_matrix (
    .sel_op   (sel_op),
    .ctx      (ctx_q),
    .soft_lock(soft_lock),
    .perm_lock(perm_lock),
    .sel_ack  (sel_ack),
    .addr_ack (addr_ack),
    .data_ack (data_ack)
  );

  spd_lock_state u_lock (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_evt   (sel_evt),
    .commit_evt(commit_evt),
    .commit_op (ctx_q.op),
    .wr_done   (wr_done),
    .soft_lock (soft_lock),
    .perm_lock (perm_lock)
  );

  // Instruction context: opened by a select byte, address half by the address byte
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctx_q <= '{op: OP_NONE, rd: 1'b0, wc: 1'b1, hit: 1'b0, upper: 1'b0};
    end else if (sel_evt) begin
      ctx_q.op    <= sel_op;
      ctx_q.rd    <= bus_byte[0];
      ctx_q.wc    <= wc_pin;
      ctx_q.hit   <= sel_ack;
      ctx_q.upper <= 1'b0;
    end else if (addr_evt) begin
      ctx_q.upper <= bus_byte[HALF_BIT];
    end
  end

  // One registered answer per strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_valid  <= 1'b0;
      ack        <= 1'b0;
      commit_ok  <= 1'b0;
      resp_sel_q <= 1'b0;
    end else begin
      ack_valid  <= ph_strobe;
      resp_sel_q <= sel_evt;
      commit_ok  <= data_evt && data_ack;
      if (sel_evt)       ack <= sel_ack;
      else if (addr_evt) ack <= addr_ack;
      else if (data_evt) ack <= data_ack;
      else               ack <= 1'b0;
    end
  end

  // R11
  ack_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> $past(ph_strobe));

  // R11
  commit_inside_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_ok |-> (ack_valid && ack));

  // R3
  wc_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_ok |-> !ctx_q.wc);

  // R8
  read_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && ack && !resp_sel_q) |-> !ctx_q.rd);

  // R4
  lower_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_ok && ctx_q.op == OP_MEM && !ctx_q.upper) |-> !soft_lock);

  // R5
  perm_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && ack && resp_sel_q && ctx_q.op != OP_MEM) |-> !$past(perm_lock));
endmodule

// File: tb/spd_wp_ctrl_tb.sv
`timescale 1ns/1ps
module spd_wp_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ph_strobe = 1'b0;
  logic [1:0] ph_kind = 2'd0;
  logic [7:0] bus_byte = 8'h00;
  logic [2:0] ce_pins = 3'b101;
  logic       hv_e0 = 1'b0;
  logic       wc_pin = 1'b0;
  logic       wr_done = 1'b0;
  logic       ack_valid, ack, commit_ok;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic  ack;
    logic  commit;
    string tag;
  } exp_t;
  exp_t expq[$];

  localparam logic [1:0] K_SEL = 2'd0, K_ADDR = 2'd1, K_DATA = 2'd2;
  localparam logic [3:0] T_MEM = 4'b1010, T_PROT = 4'b0110;

  always #2.5 clk = ~clk;

  spd_wp_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .ph_strobe(ph_strobe), .ph_kind(ph_kind),
    .bus_byte(bus_byte), .ce_pins(ce_pins), .hv_e0(hv_e0), .wc_pin(wc_pin),
    .wr_done(wr_done), .ack_valid(ack_valid), .ack(ack), .commit_ok(commit_ok)
  );

  // Monitor: answers appear one edge after the strobe, compared on the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (ack_valid) begin
        checks++;
        if (expq.size() == 0) begin
          fails++;
          $display("FAIL R11: unexpected response ack=%0b commit=%0b, expected none", ack, commit_ok);
        end else begin
          exp_t e;
          e = expq.pop_front();
          if (ack !== e.ack || commit_ok !== e.commit) begin
            fails++;
            $display("FAIL %s: ack=%0b commit=%0b, expected ack=%0b commit=%0b",
                     e.tag, ack, commit_ok, e.ack, e.commit);
          end
        end
      end else if (commit_ok) begin
        checks++;
        fails++;
        $display("FAIL R11: commit_ok=1 with ack_valid=0, expected 0");
      end
    end
  end

  task automatic step(input logic [1:0] k, input logic [7:0] b,
                      input logic ea, input logic ec, input string tag);
    expq.push_back('{ack: ea, commit: ec, tag: tag});
    @(negedge clk);
    ph_strobe = 1'b1;
    ph_kind   = k;
    bus_byte  = b;
    @(negedge clk);
    ph_strobe = 1'b0;
  endtask

  task automatic finish_wr();
    @(negedge clk);
    wr_done = 1'b1;
    @(negedge clk);
    wr_done = 1'b0;
    @(negedge clk);
  endtask

  // Three-byte write-form instruction
  task automatic instr3(input logic [3:0] t, input logic [2:0] cs, input logic [7:0] a,
                        input logic s_ack, input logic a_ack, input logic d_ack,
                        input string tag);
    step(K_SEL, {t, cs, 1'b0}, s_ack, 1'b0, tag);
    step(K_ADDR, a, a_ack, 1'b0, tag);
    step(K_DATA, 8'h3C, d_ack, d_ack, tag);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (ack_valid !== 1'b0 || commit_ok !== 1'b0) begin
      fails++;
      $display("FAIL R12: after reset ack_valid=%0b commit=%0b, expected 0 0", ack_valid, commit_ok);
    end

    // R1 select matching, mismatch, read form; R7 unlocked memory write
    ce_pins = 3'b101; hv_e0 = 1'b0; wc_pin = 1'b0;
    instr3(T_MEM, 3'b101, 8'h10, 1, 1, 1, "R7");
    finish_wr();
    step(K_SEL, {T_MEM, 3'b100, 1'b0}, 0, 0, "R1");
    step(K_ADDR, 8'h10, 0, 0, "R1");
    step(K_SEL, {T_MEM, 3'b101, 1'b1}, 1, 0, "R1");
    step(K_DATA, 8'hFF, 0, 0, "R8");

    // R3 write control high protects the upper half too
    wc_pin = 1'b1;
    instr3(T_MEM, 3'b101, 8'h90, 1, 1, 0, "R3");

    // R7 unlocked lock-set with write control high
    ce_pins = 3'b001; hv_e0 = 1'b1;
    instr3(T_PROT, 3'b001, 8'h00, 1, 1, 0, "R7");

    // R10 write control sampled at select; R9 dropped without wr_done
    wc_pin = 1'b0;
    step(K_SEL, {T_PROT, 3'b001, 1'b0}, 1, 0, "R10");
    wc_pin = 1'b1;
    step(K_ADDR, 8'h00, 1, 0, "R10");
    step(K_DATA, 8'h00, 1, 1, "R10");
    wc_pin = 1'b0;
    instr3(T_MEM, 3'b001, 8'h20, 1, 1, 1, "R9");
    finish_wr();

    // set resettable lock
    instr3(T_PROT, 3'b001, 8'h00, 1, 1, 1, "R7");
    finish_wr();

    // R4 lower half blocked, upper half open
    instr3(T_MEM, 3'b001, 8'h20, 1, 1, 0, "R4");
    instr3(T_MEM, 3'b001, 8'hA0, 1, 1, 1, "R4");
    finish_wr();

    // R6 resettable-lock behaviour
    step(K_SEL, {T_PROT, 3'b001, 1'b0}, 0, 0, "R6");
    step(K_SEL, {T_PROT, 3'b001, 1'b1}, 0, 0, "R6");
    ce_pins = 3'b011;
    step(K_SEL, {T_PROT, 3'b011, 1'b1}, 1, 0, "R8");
    step(K_ADDR, 8'h00, 0, 0, "R8");
    wc_pin = 1'b1;
    instr3(T_PROT, 3'b011, 8'h00, 1, 1, 0, "R6");
    ce_pins = 3'b101; hv_e0 = 1'b0;
    instr3(T_PROT, 3'b101, 8'h00, 1, 1, 0, "R6");
    ce_pins = 3'b011; hv_e0 = 1'b1; wc_pin = 1'b0;
    instr3(T_PROT, 3'b011, 8'h00, 1, 1, 1, "R6");
    finish_wr();
    instr3(T_MEM, 3'b011, 8'h05, 1, 1, 1, "R9");
    finish_wr();

    // R2 decode of protection selects
    ce_pins = 3'b101; hv_e0 = 1'b1;
    step(K_SEL, {T_PROT, 3'b001, 1'b0}, 0, 0, "R2");
    hv_e0 = 1'b0;
    step(K_SEL, {T_PROT, 3'b001, 1'b0}, 0, 0, "R2");
    ce_pins = 3'b001; hv_e0 = 1'b1;
    step(K_SEL, {T_PROT, 3'b101, 1'b0}, 0, 0, "R2");

    // relock, then permanent lock
    instr3(T_PROT, 3'b001, 8'h00, 1, 1, 1, "R7");
    finish_wr();
    ce_pins = 3'b101; hv_e0 = 1'b0;
    instr3(T_PROT, 3'b101, 8'h00, 1, 1, 1, "R6");
    finish_wr();

    // R5 permanent lock
    step(K_SEL, {T_PROT, 3'b101, 1'b0}, 0, 0, "R5");
    step(K_SEL, {T_PROT, 3'b101, 1'b1}, 0, 0, "R5");
    ce_pins = 3'b011; hv_e0 = 1'b1;
    step(K_SEL, {T_PROT, 3'b011, 1'b0}, 0, 0, "R5");
    ce_pins = 3'b001;
    step(K_SEL, {T_PROT, 3'b001, 1'b0}, 0, 0, "R5");
    ce_pins = 3'b101; hv_e0 = 1'b0;
    instr3(T_MEM, 3'b101, 8'h7F, 1, 1, 0, "R5");
    instr3(T_MEM, 3'b101, 8'h80, 1, 1, 1, "R5");
    finish_wr();

    // R12 reset clears context, not locks
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (ack_valid !== 1'b0 || commit_ok !== 1'b0) begin
      fails++;
      $display("FAIL R12: after second reset ack_valid=%0b commit=%0b, expected 0 0", ack_valid, commit_ok);
    end
    step(K_ADDR, 8'h90, 0, 0, "R12");
    step(K_DATA, 8'h11, 0, 0, "R12");
    step(K_SEL, {T_PROT, 3'b101, 1'b0}, 0, 0, "R12");
    instr3(T_MEM, 3'b101, 8'h00, 1, 1, 0, "R12");

    repeat (3) @(negedge clk);
    checks++;
    if (expq.size() != 0) begin
      fails++;
      $display("FAIL R11: %0d responses missing, expected 0", expq.size());
    end
    summary();
  end
endmodule